// File: doc/BRIEF.md
# Reference-Preset Period Error Counter

This block measures how far a motor is from its target speed, once in every period of a reference pulse derived from the tachometer. On the chosen edge of that pulse it does two things. It turns the residue of a down-counter into a signed error, and it reloads the counter with a programmed reference count. Between two such edges the counter steps down by one on every cycle in which the count enable is high. A period longer than the reference leaves the residue below zero, and the latched error is then positive. A period that matches the reference exactly gives an error of zero.

The error goes to a downstream filter together with a one-cycle valid strobe. If the counter reaches its most negative value and is asked to step once more, it stops there and sets a sticky overflow flag. Software clears that flag with a read that returns 1 followed by a write of 0. A one-cycle period interrupt reports every latch and every overflow.

Top module: `period_err_cnt`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, err_out is 0 and err_valid, ovf_flag and period_irq are all low.
- R2: edge_sel = 1 makes a rising edge of ref_pulse the active edge, and edge_sel = 0 makes a falling edge the active edge. The outputs react on the third rising clock edge after the pulse level is first sampled changed: two synchronizer stages, then the edge register.
- R3: At an active edge the counter is loaded with preset_val, which is read as signed 16-bit. After that it decrements by one on each clock cycle in which cnt_en is 1.
- R4: At an active edge err_out takes the two's-complement negation of the counter residue. With cnt_en held at 1 and a period of P cycles, the residue is preset_val − (P − 1). The error is therefore positive for a longer period, negative for a shorter one and 0 when P − 1 equals preset_val.
- R5: err_valid is high for exactly one cycle, the cycle in which err_out shows the new value.
- R6: When the counter holds 0x8000 and cnt_en is 1 with no active edge, the counter stops and ovf_flag is set. The counter then holds 0x8000 until the next active edge. If an active edge falls in the same cycle, the edge wins and no overflow occurs.
- R7: A residue of 0x8000 is latched as err_out = 0x7FFF.
- R8: period_irq is a one-cycle pulse for each latch, in the same cycle as err_valid, and for each overflow, on the cycle after it.
- R9: A write with flag_wdata = 0 clears ovf_flag only if flag_rd sampled ovf_flag = 1 after the previous write. Any write uses up that permission. A write with flag_wdata = 1 leaves the flag unchanged.
- R10: A write of 0 with no qualifying read before it leaves ovf_flag set.
- R11: If an overflow and a qualifying clearing write land in the same cycle, ovf_flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | Reference pulse, asynchronous to clk |
| cnt_en | input | 1 | Count-down enable for the counter |
| edge_sel | input | 1 | 1: rising active edge, 0: falling active edge |
| preset_val | input | 16 | Reference count loaded at each active edge |
| flag_rd | input | 1 | Read strobe for the overflow flag |
| flag_wr | input | 1 | Write strobe for the overflow flag |
| flag_wdata | input | 1 | Data bit of the flag write |
| err_out | output | 16 | Signed speed error |
| err_valid | output | 1 | One-cycle strobe for a new err_out |
| ovf_flag | output | 1 | Sticky overflow flag |
| period_irq | output | 1 | One-cycle interrupt on each latch or overflow |

## Verification
Two functions can meet in one cycle: the hardware setting the overflow flag, and a qualified write of 0 that tries to clear it. The bench arms the clearing permission with a read and then starts a new period from a preset just above 0x8000. It watches its own model until it predicts an overflow on the next edge, and issues the clearing write in exactly that cycle. The flag must read 1 afterwards, and a second write of 0, now without permission, must still leave it at 1.

// File: rtl/period_err_cnt.sv
module period_err_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ref_pulse,
  input  logic         cnt_en,
  input  logic         edge_sel,
  input  logic [W-1:0] preset_val,
  input  logic         flag_rd,
  input  logic         flag_wr,
  input  logic         flag_wdata,
  output logic [W-1:0] err_out,
  output logic         err_valid,
  output logic         ovf_flag,
  output logic         period_irq
);
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_P = {1'b0, {(W-1){1'b1}}};

  logic [2:0]   sync_q;
  logic [W-1:0] cnt;
  logic         stopped;
  logic         clr_tok;

  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire evt     = edge_sel ? rise : fall;
  wire at_min  = (cnt == MIN_V);
  wire ovf_set = ~evt & cnt_en & ~stopped & at_min;
  wire clr_ok  = flag_wr & ~flag_wdata & clr_tok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_pulse};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else if (evt) begin
      cnt     <= preset_val;
      stopped <= 1'b0;
    end else if (cnt_en && !stopped) begin
      if (at_min) stopped <= 1'b1;
      else        cnt     <= cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_out    <= '0;
      err_valid  <= 1'b0;
      period_irq <= 1'b0;
    end else begin
      err_valid  <= evt;
      period_irq <= evt | ovf_set;
      if (evt) err_out <= at_min ? MAX_P : (~cnt + 1'b1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      clr_tok  <= 1'b0;
    end else begin
      if (ovf_set)     ovf_flag <= 1'b1;
      else if (clr_ok) ovf_flag <= 1'b0;
      if (flag_wr)                  clr_tok <= 1'b0;
      else if (flag_rd && ovf_flag) clr_tok <= 1'b1;
    end

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cnt == $past(preset_val)); // R3

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !evt) |=> (cnt == $past(cnt))); // R6

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid); // R5

  AST_IRQ_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> period_irq); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_wr) |=> ovf_flag); // R10
endmodule

// File: tb/period_err_cnt_tb_top.sv
module period_err_cnt_tb_top;
  logic clk = 1'b0;
  logic rst_n, ref_pulse, cnt_en, edge_sel, flag_rd, flag_wr, flag_wdata;
  logic [15:0] preset_val;
  logic [15:0] err_out;
  logic err_valid, ovf_flag, period_irq;

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0;

  always #2 clk = ~clk;

  period_err_cnt #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .cnt_en(cnt_en),
    .edge_sel(edge_sel), .preset_val(preset_val), .flag_rd(flag_rd),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .err_out(err_out),
    .err_valid(err_valid), .ovf_flag(ovf_flag), .period_irq(period_irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit ph[$];
  int m_cnt, m_err;
  bit m_stop, m_val, m_irq, m_flag, m_tok;

  always @(posedge clk) begin
    bit ev, ovs, old_flag, old_tok;
    cyc++;
    if (!rst_n) begin
      ph = {1'b0, 1'b0, 1'b0};
      m_cnt = 0; m_err = 0; m_stop = 0; m_val = 0; m_irq = 0; m_flag = 0; m_tok = 0;
    end else begin
      ev  = edge_sel ? (ph[1] && !ph[2]) : (!ph[1] && ph[2]);
      ovs = !ev && cnt_en && !m_stop && (m_cnt == -32768);
      ph.push_front(ref_pulse);
      void'(ph.pop_back());
      m_val = ev;
      m_irq = ev || ovs;
      if (ev) begin
        m_err  = (m_cnt == -32768) ? 32767 : -m_cnt;
        m_cnt  = int'($signed(preset_val));
        m_stop = 0;
      end else if (cnt_en && !m_stop) begin
        if (m_cnt == -32768) m_stop = 1;
        else m_cnt = m_cnt - 1;
      end
      old_flag = m_flag; old_tok = m_tok;
      if (ovs) m_flag = 1;
      else if (flag_wr && !flag_wdata && old_tok) m_flag = 0;
      if (flag_wr) m_tok = 0;
      else if (flag_rd && old_flag) m_tok = 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R4 err_out vs model", int'(err_out), int'(m_err[15:0]));
      chk("R5 err_valid vs model", int'(err_valid), int'(m_val));
      chk("R9 ovf_flag vs model", int'(ovf_flag), int'(m_flag));
      chk("R8 period_irq vs model", int'(period_irq), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  task automatic run(input bit sel, input logic [15:0] pv, input int p, input int n,
                     input bit gate, input bit dochk, input int expv, input string tag);
    int last = 0, seen = 0;
    edge_sel = sel; preset_val = pv;
    for (int i = 0; i < n * p; i++) begin
      ref_pulse = ((i % p) < p / 2);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cnt_en = gate ? lfsr[0] : 1'b1;
      @(negedge clk);
      if (err_valid) begin last = $signed(err_out); seen++; end
    end
    if (dochk) begin
      chk({tag, " valid count"}, (seen >= 3) ? 1 : 0, 1);
      chk(tag, last, expv);
    end
  endtask

  task automatic flag_op(input bit rd, input bit wr, input bit wd);
    flag_rd = rd; flag_wr = wr; flag_wdata = wd;
    @(negedge clk);
    flag_rd = 0; flag_wr = 0; flag_wdata = 0;
  endtask

  initial begin
    int guard;
    rst_n = 0; ref_pulse = 0; cnt_en = 0; edge_sel = 1; preset_val = 0;
    flag_rd = 0; flag_wr = 0; flag_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 err_out in reset", int'(err_out), 0);
    chk("R1 err_valid in reset", int'(err_valid), 0);
    chk("R1 ovf_flag in reset", int'(ovf_flag), 0);
    chk("R1 period_irq in reset", int'(period_irq), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 err_out after reset", int'(err_out), 0);
    started = 1;

    run(1, 16'd19, 20, 6, 0, 1, 0,   "R4 exact speed gives zero");
    run(1, 16'd19, 26, 5, 0, 1, 6,   "R4 slow gives positive");
    run(1, 16'd19, 15, 6, 0, 1, -5,  "R4 fast gives negative");
    run(0, 16'd40, 30, 5, 0, 1, -11, "R2 falling edge select");
    run(1, 16'd30, 24, 4, 0, 1, -7,  "R2 rising edge select");
    run(1, 16'd100, 40, 5, 1, 0, 0,  "R3 gated count");
    run(0, 16'd8, 36, 5, 1, 0, 0,    "R3 gated count falling");

    // overflow: counter starts close to 0x8000 and the period is long
    edge_sel = 1; preset_val = 16'h8004; cnt_en = 1; ref_pulse = 1;
    repeat (30) @(negedge clk);
    chk("R6 overflow sets flag", int'(ovf_flag), 1);
    flag_op(1, 0, 0);
    ref_pulse = 0;
    repeat (5) @(negedge clk);
    ref_pulse = 1;
    guard = 0;
    while (!(m_cnt == -32768 && !m_stop) && guard < 50) begin
      @(negedge clk);
      if (err_valid) chk("R7 stopped residue latches 7FFF", int'(err_out), 32'h7FFF);
      guard++;
    end
    chk("R11 collision reached", (guard < 50) ? 1 : 0, 1);
    flag_op(0, 1, 0);
    chk("R11 set beats clearing write", int'(ovf_flag), 1);
    flag_op(0, 1, 0);
    chk("R10 zero write without read keeps flag", int'(ovf_flag), 1);
    flag_op(1, 0, 0);
    flag_op(0, 1, 1);
    chk("R9 write of one keeps flag", int'(ovf_flag), 1);
    flag_op(1, 0, 0);
    flag_op(0, 1, 0);
    chk("R9 read then zero write clears", int'(ovf_flag), 0);
    repeat (5) @(negedge clk);
    chk("R6 flag stays clear while stopped", int'(ovf_flag), 0);

    ref_pulse = 0;
    run(1, 16'd19, 20, 4, 0, 1, 0, "R6 restart after stop");

    started = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule